// File: doc/BRIEF.md
# Sticky Event Status and Dual Interrupt Unit

This unit collects single-cycle event pulses from the command and data paths of a card host controller, together with level flags that describe path activity and FIFO fill state, and presents them as one 22-bit status word. The eleven low positions hold sticky event flags. A flag is set by its pulse and stays set until software writes a one to the matching position of the clear register. The eleven high positions follow their live inputs directly and cannot be cleared.

Two mask registers use the same layout as the status word. Each one gates the status word onto its own registered, active-high interrupt line. One line is intended for completion and error events, and the other for FIFO servicing. Software reaches the status word, the clear register and both masks through a small register port. Writes take effect at the clock edge, and reads return data combinationally from the selected address.

Top module: `sirq_unit`

## Requirements
- R1: A pulse on `evt_i[k]`, for k in 0..8 or k = 10, sets status bit k at the next clock edge. The bit then holds at 1 for as long as no clear write names it.
- R2: A write to address 1 (clear) with bit k of the write data at 1 clears status bit k at that edge. Bits written as 0 are left unchanged, and writing 0x7FF clears every sticky flag. A read of address 1 returns zero.
- R3: Status bits 11..21 equal `live_i[0..10]` in the same cycle, read at address 0. A clear write has no effect on them.
- R4: Bit 9 is reserved. It reads as 0 in the status word and in both masks, and both `evt_i[9]` and writes to bit 9 are ignored.
- R5: Address 2 holds the mask for `irq_done_o` and address 3 holds the mask for `irq_fifo_o`. Each mask stores all 22 bits except bit 9, and each reads back what was written.
- R6: `irq_done_o` is the registered OR of (status AND mask at address 2). `irq_fifo_o` is the same function using the mask at address 3. The two lines are independent of each other.
- R7: After reset, every sticky flag and both masks are zero, and both interrupt lines are low.
- R8: When an event pulse and a clear write name the same bit in the same cycle, the event wins and the bit is 1 after that edge.
- R9: An interrupt line rises one cycle after its status bit becomes set and unmasked. It falls one cycle after that bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 11 | Event pulses for status bits 0..10 (bit 9 ignored) |
| live_i | input | 11 | Live condition flags shown at status bits 11..21 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 clear, 2 done mask, 3 FIFO mask |
| reg_wdata_i | input | 22 | Register write data |
| reg_rdata_o | output | 22 | Read data for the addressed register |
| irq_done_o | output | 1 | Completion and error interrupt |
| irq_fifo_o | output | 1 | FIFO service interrupt |

## Verification
The two functions that can land in the same cycle are the setting of a sticky flag by its event pulse and the clearing of that flag by a software write. The bench drives both in one cycle, sometimes on the same bits and sometimes on disjoint bits. The same-bit case is judged correct only when the flag reads 1 afterwards. In the disjoint case, the cleared bits must read 0 while the newly set bits read 1. A checker also confirms, on every cycle, that a pulse leaves its flag set, and that a clear drops every named flag that had no event in that cycle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int EVT_W   = 11;
    localparam int LIVE_W  = 11;
    localparam int FLAG_W  = EVT_W + LIVE_W;
    localparam int RSV_IDX = 9;
    localparam int ADDR_W  = 2;
    localparam int N_LINES = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_FLAGS = 2'd0,
        SEL_CLEAR = 2'd1,
        SEL_MASK0 = 2'd2,
        SEL_MASK1 = 2'd3
    } sel_e;

endpackage

// File: rtl/sirq_event_bank.sv
module sirq_event_bank #(
    parameter int EVT_W   = 11,
    parameter int RSV_IDX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             clr_we_i,
    input  logic [EVT_W-1:0] clr_bits_i,
    output logic [EVT_W-1:0] sticky_o
);

    localparam logic [EVT_W-1:0] KEEP = ~(EVT_W'(1) << RSV_IDX);

    typedef struct packed {
        logic [EVT_W-1:0] bits;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr_we_i) begin
            bank_d.bits = bank_d.bits & ~clr_bits_i;
        end
        // a pulse in the same cycle as a clear keeps the flag set
        bank_d.bits = (bank_d.bits | evt_i) & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign sticky_o = bank_q.bits;

endmodule

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg #(
    parameter int W       = 22,
    parameter int RSV_IDX = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    localparam logic [W-1:0] KEEP = ~(W'(1) << RSV_IDX);

    typedef struct packed {
        logic [W-1:0] bits;
    } mask_t;

    mask_t mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_en_i) begin
            mask_d.bits = wdata_i & KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q.bits;

endmodule

// File: rtl/sirq_irq_gen.sv
module sirq_irq_gen #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    typedef struct packed {
        logic line;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d      = irq_q;
        irq_d.line = |(flags_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q.line;

endmodule

// File: rtl/sirq_unit.sv
module sirq_unit
    import sirq_pkg::*;
#(
    parameter int P_EVT_W   = EVT_W,
    parameter int P_LIVE_W  = LIVE_W,
    parameter int P_RSV_IDX = RSV_IDX
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [P_EVT_W-1:0]            evt_i,
    input  logic [P_LIVE_W-1:0]           live_i,
    input  logic                          reg_we_i,
    input  logic [ADDR_W-1:0]             reg_addr_i,
    input  logic [P_EVT_W+P_LIVE_W-1:0]   reg_wdata_i,
    output logic [P_EVT_W+P_LIVE_W-1:0]   reg_rdata_o,
    output logic                          irq_done_o,
    output logic                          irq_fifo_o
);

    localparam int FW = P_EVT_W + P_LIVE_W;

    logic [P_EVT_W-1:0] sticky_w;
    logic [FW-1:0]      status_w;
    logic [FW-1:0]      mask_w [N_LINES];
    logic               irq_w  [N_LINES];
    logic               clr_we_w;
    sel_e               sel_w;

    assign sel_w    = sel_e'(reg_addr_i);
    assign clr_we_w = reg_we_i && (sel_w == SEL_CLEAR);

    sirq_event_bank #(
        .EVT_W   (P_EVT_W),
        .RSV_IDX (P_RSV_IDX)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_we_i   (clr_we_w),
        .clr_bits_i (reg_wdata_i[P_EVT_W-1:0]),
        .sticky_o   (sticky_w)
    );

    assign status_w = {live_i, sticky_w};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic sel_hit;
        assign sel_hit = reg_we_i && (sel_w == ((g == 0) ? SEL_MASK0 : SEL_MASK1));

        sirq_mask_reg #(
            .W       (FW),
            .RSV_IDX (P_RSV_IDX)
        ) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en_i (sel_hit),
            .wdata_i (reg_wdata_i),
            .mask_o  (mask_w[g])
        );

        sirq_irq_gen #(
            .W (FW)
        ) u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .flags_i (status_w),
            .mask_i  (mask_w[g]),
            .irq_o   (irq_w[g])
        );
    end

    assign irq_done_o = irq_w[0];
    assign irq_fifo_o = irq_w[1];

    always_comb begin
        unique case (sel_w)
            SEL_FLAGS: reg_rdata_o = status_w;
            SEL_MASK0: reg_rdata_o = mask_w[0];
            SEL_MASK1: reg_rdata_o = mask_w[1];
            default:   reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/sirq_unit_chk.sv
module sirq_unit_chk
    import sirq_pkg::*;
#(
    parameter int C_EVT_W   = EVT_W,
    parameter int C_FLAG_W  = FLAG_W,
    parameter int C_RSV_IDX = RSV_IDX
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [C_EVT_W-1:0]    evt_i,
    input logic                  reg_we_i,
    input logic [ADDR_W-1:0]     reg_addr_i,
    input logic [C_FLAG_W-1:0]   reg_wdata_i,
    input logic [C_FLAG_W-1:0]   flags,
    input logic [C_FLAG_W-1:0]   mask_a,
    input logic [C_FLAG_W-1:0]   mask_b,
    input logic                  irq_done_o,
    input logic                  irq_fifo_o
);

    localparam logic [C_EVT_W-1:0] VALID = ~(C_EVT_W'(1) << C_RSV_IDX);

    logic                clr_wr;
    logic [C_EVT_W-1:0]  evt_v;
    logic [C_EVT_W-1:0]  stick;

    assign clr_wr = reg_we_i && (reg_addr_i == SEL_CLEAR);
    assign evt_v  = evt_i & VALID;
    assign stick  = flags[C_EVT_W-1:0];

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_v) |=> ((stick & $past(evt_v)) == $past(evt_v))); // R1

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((stick & $past(stick)) == $past(stick))); // R1

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((stick & $past(reg_wdata_i[C_EVT_W-1:0] & ~evt_v)) == '0)); // R2

    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && |(evt_v & reg_wdata_i[C_EVT_W-1:0]))
        |=> ((stick & $past(evt_v & reg_wdata_i[C_EVT_W-1:0]))
             == $past(evt_v & reg_wdata_i[C_EVT_W-1:0]))); // R8

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[C_RSV_IDX] && !mask_a[C_RSV_IDX] && !mask_b[C_RSV_IDX]); // R4

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_done_o == $past(|(flags & mask_a)))); // R9

    AST_FIFO_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_fifo_o == $past(|(flags & mask_b)))); // R6

endmodule

bind sirq_unit sirq_unit_chk #(
    .C_EVT_W   (P_EVT_W),
    .C_FLAG_W  (P_EVT_W + P_LIVE_W),
    .C_RSV_IDX (P_RSV_IDX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .flags       (status_w),
    .mask_a      (mask_w[0]),
    .mask_b      (mask_w[1]),
    .irq_done_o  (irq_done_o),
    .irq_fifo_o  (irq_fifo_o)
);

// File: tb/sirq_unit_tb.sv
module sirq_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt_i = '0;
    logic [10:0] live_i = '0;
    logic        reg_we_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [21:0] reg_wdata_i = '0;
    logic [21:0] reg_rdata_o;
    logic        irq_done_o;
    logic        irq_fifo_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sirq_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .live_i      (live_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_done_o  (irq_done_o),
        .irq_fifo_o  (irq_fifo_o)
    );

    // fields: event pulse, live flags, clear data, read address, expected read
    localparam int NV = 9;
    localparam logic [56:0] VEC [NV] = '{
        {11'h001, 11'h000, 11'h000, 2'd0, 22'h000001},  // R1 set bit 0
        {11'h400, 11'h7FF, 11'h000, 2'd0, 22'h3FFC01},  // R3 live all ones, R1 bit 10
        {11'h200, 11'h000, 11'h000, 2'd0, 22'h000401},  // R4 event bit 9 ignored
        {11'h000, 11'h005, 11'h001, 2'd0, 22'h002C00},  // R2 clear bit 0, R3 live kept
        {11'h0F0, 11'h000, 11'h0F0, 2'd0, 22'h0004F0},  // R8 event beats clear
        {11'h10F, 11'h000, 11'h400, 2'd0, 22'h0001FF},  // R2 disjoint clear and set
        {11'h000, 11'h400, 11'h7FF, 2'd0, 22'h200000},  // R2 clear all, R3 live bit 21
        {11'h7FF, 11'h000, 11'h000, 2'd1, 22'h000000},  // R2 clear address reads zero
        {11'h000, 11'h000, 11'h000, 2'd0, 22'h0005FF}   // R4 bit 9 stays zero
    };

    task automatic chk(input string req, input logic [21:0] act, input logic [21:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [21:0] d);
        @(negedge clk);
        reg_we_i    = 1'b1;
        reg_addr_i  = a;
        reg_wdata_i = d;
        @(posedge clk);
        #1;
        reg_we_i    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [21:0] exp);
        reg_addr_i = a;
        #1;
        chk(req, reg_rdata_o, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rd_chk("R7 status after reset", 2'd0, 22'h0);
        rd_chk("R7 done mask after reset", 2'd2, 22'h0);
        rd_chk("R7 fifo mask after reset", 2'd3, 22'h0);
        chk("R7 irq lines in reset", {20'h0, irq_done_o, irq_fifo_o}, 22'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R7 irq lines after reset", {20'h0, irq_done_o, irq_fifo_o}, 22'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            evt_i       = VEC[i][56:46];
            live_i      = VEC[i][45:35];
            reg_we_i    = 1'b1;
            reg_addr_i  = 2'd1;
            reg_wdata_i = {11'h0, VEC[i][34:24]};
            @(posedge clk);
            #1;
            evt_i    = '0;
            reg_we_i = 1'b0;
            rd_chk($sformatf("vector %0d R1 R2 R3 R4 R8", i), VEC[i][23:22], VEC[i][21:0]);
        end

        // mask storage, bit 9 dropped
        wr(2'd2, 22'h3FFFFF);
        rd_chk("R5 R4 done mask readback", 2'd2, 22'h3FFDFF);
        wr(2'd3, 22'h2AAAAA);
        rd_chk("R5 R4 fifo mask readback", 2'd3, 22'h2AA8AA);

        // interrupt timing
        wr(2'd1, 22'h0007FF);
        live_i = '0;
        wr(2'd2, 22'h000001);
        wr(2'd3, 22'h004000);
        @(posedge clk);
        #1;
        chk("R6 both lines quiet", {20'h0, irq_done_o, irq_fifo_o}, 22'h0);
        @(negedge clk);
        evt_i = 11'h001;
        @(posedge clk);
        #1;
        evt_i = '0;
        chk("R9 done low in set cycle", {21'h0, irq_done_o}, 22'h0);
        @(posedge clk);
        #1;
        chk("R9 done high one cycle later", {21'h0, irq_done_o}, 22'h1);
        chk("R6 fifo line independent", {21'h0, irq_fifo_o}, 22'h0);
        @(negedge clk);
        live_i = 11'h008;
        @(posedge clk);
        #1;
        chk("R6 fifo line from live bit 14", {21'h0, irq_fifo_o}, 22'h1);
        wr(2'd1, 22'h000001);
        chk("R9 done still high at clear edge", {21'h0, irq_done_o}, 22'h1);
        @(posedge clk);
        #1;
        chk("R9 done low one cycle after clear", {21'h0, irq_done_o}, 22'h0);
        wr(2'd1, 22'h0007FF);
        rd_chk("R3 clear leaves live bit", 2'd0, 22'h004000);
        chk("R3 fifo line unaffected by clear", {21'h0, irq_fifo_o}, 22'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule